// File: doc/BRIEF.md
# CBC Chaining Word-Stream Controller

This block sits between a host bus and a 128-bit block-cipher core and performs cipher block chaining for encryption over any number of blocks. The host first loads a 128-bit initialization vector. It then writes plaintext one 32-bit word at a time and reads ciphertext one 32-bit word at a time. The controller packs four words into a block and combines that block by XOR with the chaining value: the initialization vector for the first block, and the previous ciphertext for every later block. It launches the core with this input and captures the result in two places: an output buffer that is drained word by word, and the chaining register.

Progress is reported in two ways: an encoded interrupt index, and a pair of DMA request lines. One request line serves the input channel and one serves the output channel, and each request edge stands for one 32-bit transfer. A new block is not sent to the core until the previous ciphertext block has been fully read, so the output buffer can never be overwritten before it is read.

Top module: `cbc_word_chain`

## Requirements
- R1: After reset, in_rdy=1, out_rdy=0, irq_idx=2, core_start=0, dma_trig_in=1 and dma_trig_out=0.
- R2: The first accepted input word of a block lands in block bits 31:0, and each later word fills the next higher 32 bits.
- R3: The core input of the first block after an IV load equals that block XOR the loaded IV.
- R4: The core input of every later block equals that block XOR the previous ciphertext, and the ciphertext delivered is exactly the core output.
- R5: out_rdata shows ciphertext bits 31:0 first, and each accepted read advances it to the next higher 32 bits.
- R6: in_rdy is 0 from the cycle after the fourth accepted write until the core finishes, and a write while in_rdy=0 is ignored.
- R7: out_rdy stays 1 until the fourth read of the block is accepted and falls right after it, and a read while out_rdy=0 is ignored.
- R8: irq_idx is 1 while out_rdy=1 (even when in_rdy=1), 2 while only in_rdy=1, and 0 when neither is set.
- R9: dma_trig_in is 1 only while in_rdy=1 and is 0 in the cycle after every accepted write; dma_trig_out is 1 only while out_rdy=1 and is 0 in the cycle after every accepted read.
- R10: No core_start is issued while a ciphertext block is still waiting to be read.
- R11: Loading a new IV replaces the chaining value, so the next block is combined with the new IV.
- R12: core_start is a one-cycle pulse issued exactly once per complete input block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iv_load | input | 1 | Load iv_in into the chaining register |
| iv_in | input | 128 | Initialization vector |
| in_we | input | 1 | Plaintext word write strobe |
| in_wdata | input | 32 | Plaintext word |
| out_re | input | 1 | Ciphertext word read strobe (pops the shown word) |
| out_rdata | output | 32 | Current ciphertext word |
| in_rdy | output | 1 | Input buffer can take words |
| out_rdy | output | 1 | Ciphertext block available |
| irq_idx | output | 2 | Interrupt index: 1 output ready, 2 input ready, 0 none |
| dma_trig_in | output | 1 | Input-channel DMA request |
| dma_trig_out | output | 1 | Output-channel DMA request |
| core_start | output | 1 | Launch pulse to the cipher core |
| core_din | output | 128 | Chained block to the cipher core |
| core_done | input | 1 | Cipher core finished |
| core_dout | input | 128 | Cipher core result |

## Verification
After the fourth write, in_rdy and dma_trig_in are low one cycle later. core_start follows one cycle after that. The stand-in core raises core_done on the next cycle, and out_rdy rises one cycle after core_done. A request line is low one cycle after each transfer, and out_rdata advances one cycle after each read. Stimulus is applied at falling edges, and every output is sampled at the falling edge that follows the rising edge where it is due. The bench also waits on out_rdy with a bounded loop, so a changed latency still lands on the right sample. The core input is captured on the rising edge where core_start is high, and expected ciphertext comes from the bench's own chaining model.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [1:0] {
    IRQ_NONE = 2'd0,
    IRQ_OUT  = 2'd1,
    IRQ_IN   = 2'd2
  } irq_e;
endpackage

// File: rtl/cbc_in_packer.sv
module cbc_in_packer #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BLK_W = WORD_W * WORDS,
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              release_blk,
  output logic              full,
  output logic [BLK_W-1:0]  blk,
  output logic              trig
);
  logic [CNT_W-1:0] cnt_q;
  logic             full_q;
  logic             gap_q;
  logic             accept;

  assign accept = wr_en && !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      gap_q <= accept;
      if (accept) begin
        if (cnt_q == CNT_W'(WORDS - 1)) begin
          cnt_q  <= '0;
          full_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (release_blk) begin
        full_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (accept && cnt_q == CNT_W'(i)) begin
        slot_q <= wr_data;
      end
    end
    assign blk[i*WORD_W +: WORD_W] = slot_q;
  end

  assign full = full_q;
  assign trig = !full_q && !gap_q;
endmodule

// File: rtl/cbc_out_unpacker.sv
module cbc_out_unpacker #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BLK_W = WORD_W * WORDS,
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BLK_W-1:0]  load_blk,
  input  logic              rd_en,
  output logic              valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              trig
);
  logic [BLK_W-1:0] buf_q;
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;
  logic             gap_q;
  logic             pop;

  assign pop = rd_en && valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      gap_q   <= 1'b0;
    end else begin
      gap_q <= pop;
      if (load) begin
        buf_q   <= load_blk;
        cnt_q   <= '0;
        valid_q <= 1'b1;
      end else if (pop) begin
        if (cnt_q == CNT_W'(WORDS - 1)) begin
          cnt_q   <= '0;
          valid_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rd_data = buf_q[cnt_q*WORD_W +: WORD_W];
  assign valid   = valid_q;
  assign trig    = valid_q && !gap_q;
endmodule

// File: rtl/cbc_chain_ctrl.sv
module cbc_chain_ctrl #(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iv_load,
  input  logic [BLK_W-1:0] iv_in,
  input  logic             blk_full,
  input  logic [BLK_W-1:0] in_blk,
  input  logic             out_pending,
  input  logic             core_done,
  input  logic [BLK_W-1:0] core_dout,
  output logic             core_start,
  output logic [BLK_W-1:0] core_din,
  output logic             finish
);
  logic [BLK_W-1:0] chain_q;
  logic [BLK_W-1:0] din_q;
  logic             busy_q;
  logic             start_q;
  logic             launch;

  assign launch = blk_full && !busy_q && !out_pending;
  assign finish = busy_q && core_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      din_q   <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= launch;
      if (iv_load) begin
        chain_q <= iv_in;
      end else if (finish) begin
        chain_q <= core_dout;
      end
      if (launch) begin
        busy_q <= 1'b1;
        din_q  <= in_blk ^ chain_q;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign core_start = start_q;
  assign core_din   = din_q;
endmodule

// File: rtl/cbc_word_chain.sv
module cbc_word_chain #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BLK_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iv_load,
  input  logic [BLK_W-1:0]  iv_in,
  input  logic              in_we,
  input  logic [WORD_W-1:0] in_wdata,
  input  logic              out_re,
  output logic [WORD_W-1:0] out_rdata,
  output logic              in_rdy,
  output logic              out_rdy,
  output logic [1:0]        irq_idx,
  output logic              dma_trig_in,
  output logic              dma_trig_out,
  output logic              core_start,
  output logic [BLK_W-1:0]  core_din,
  input  logic              core_done,
  input  logic [BLK_W-1:0]  core_dout
);
  import cbc_pkg::*;

  logic             blk_full;
  logic [BLK_W-1:0] in_blk;
  logic             finish;
  logic             out_valid;
  irq_e             irq_sel;

  cbc_in_packer #(.WORD_W(WORD_W), .WORDS(WORDS)) i_pack (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (in_we),
    .wr_data     (in_wdata),
    .release_blk (finish),
    .full        (blk_full),
    .blk         (in_blk),
    .trig        (dma_trig_in)
  );

  cbc_chain_ctrl #(.BLK_W(BLK_W)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .iv_load     (iv_load),
    .iv_in       (iv_in),
    .blk_full    (blk_full),
    .in_blk      (in_blk),
    .out_pending (out_valid),
    .core_done   (core_done),
    .core_dout   (core_dout),
    .core_start  (core_start),
    .core_din    (core_din),
    .finish      (finish)
  );

  cbc_out_unpacker #(.WORD_W(WORD_W), .WORDS(WORDS)) i_unpack (
    .clk      (clk),
    .rst      (rst),
    .load     (finish),
    .load_blk (core_dout),
    .rd_en    (out_re),
    .valid    (out_valid),
    .rd_data  (out_rdata),
    .trig     (dma_trig_out)
  );

  always_comb begin
    if (out_valid)      irq_sel = IRQ_OUT;
    else if (!blk_full) irq_sel = IRQ_IN;
    else                irq_sel = IRQ_NONE;
  end

  assign in_rdy  = !blk_full;
  assign out_rdy = out_valid;
  assign irq_idx = irq_sel;
endmodule

// File: rtl/cbc_word_chain_chk.sv
module cbc_word_chain_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_we,
  input logic       in_rdy,
  input logic       out_re,
  input logic       out_rdy,
  input logic [1:0] irq_idx,
  input logic       dma_trig_in,
  input logic       dma_trig_out,
  input logic       core_start
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start); // R12
  AST_LAUNCH_DRAINED: assert property (@(posedge clk) disable iff (rst)
    core_start |-> !out_rdy); // R10
  AST_IN_RDY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(in_rdy) |-> $past(in_we)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_rdy && !out_re) |=> out_rdy); // R7
  AST_IRQ_OUT_FIRST: assert property (@(posedge clk) disable iff (rst)
    out_rdy |-> irq_idx == 2'd1); // R8
  AST_IRQ_IN: assert property (@(posedge clk) disable iff (rst)
    (!out_rdy && in_rdy) |-> irq_idx == 2'd2); // R8
  AST_TRIG_IN_RDY: assert property (@(posedge clk) disable iff (rst)
    dma_trig_in |-> in_rdy); // R9
  AST_TRIG_IN_GAP: assert property (@(posedge clk) disable iff (rst)
    (in_we && in_rdy) |=> !dma_trig_in); // R9
  AST_TRIG_OUT_RDY: assert property (@(posedge clk) disable iff (rst)
    dma_trig_out |-> out_rdy); // R9
  AST_TRIG_OUT_GAP: assert property (@(posedge clk) disable iff (rst)
    (out_re && out_rdy) |=> !dma_trig_out); // R9
endmodule

bind cbc_word_chain cbc_word_chain_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .in_we        (in_we),
  .in_rdy       (in_rdy),
  .out_re       (out_re),
  .out_rdy      (out_rdy),
  .irq_idx      (irq_idx),
  .dma_trig_in  (dma_trig_in),
  .dma_trig_out (dma_trig_out),
  .core_start   (core_start)
);

// File: tb/test_cbc_word_chain.sv
module test_cbc_word_chain;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         iv_load = 1'b0;
  logic [127:0] iv_in = '0;
  logic         in_we = 1'b0;
  logic [31:0]  in_wdata = '0;
  logic         out_re = 1'b0;
  logic [31:0]  out_rdata;
  logic         in_rdy, out_rdy, dma_trig_in, dma_trig_out, core_start;
  logic [1:0]   irq_idx;
  logic [127:0] core_din;
  logic         core_done = 1'b0;
  logic [127:0] core_dout = '0;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int cyc = 0;
  logic [127:0] last_din = '0;
  logic [127:0] prev_c;

  always #2 clk = ~clk;

  cbc_word_chain i_cbc_word_chain (
    .clk(clk), .rst(rst), .iv_load(iv_load), .iv_in(iv_in),
    .in_we(in_we), .in_wdata(in_wdata), .out_re(out_re), .out_rdata(out_rdata),
    .in_rdy(in_rdy), .out_rdy(out_rdy), .irq_idx(irq_idx),
    .dma_trig_in(dma_trig_in), .dma_trig_out(dma_trig_out),
    .core_start(core_start), .core_din(core_din),
    .core_done(core_done), .core_dout(core_dout)
  );

  function automatic logic [127:0] xform(input logic [127:0] x);
    return {x[95:0], x[127:96]} ^ 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
  endfunction

  always @(posedge clk) begin
    core_done <= core_start;
    core_dout <= xform(core_din);
    if (core_start) begin
      starts++;
      last_din = core_din;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: act cycles %0d exp below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic load_iv(input logic [127:0] v);
    iv_load = 1'b1; iv_in = v;
    @(negedge clk);
    iv_load = 1'b0;
  endtask

  task automatic write_word(input logic [31:0] w);
    in_we = 1'b1; in_wdata = w;
    @(negedge clk);
    in_we = 1'b0;
  endtask

  task automatic write_block(input logic [127:0] p);
    for (int k = 0; k < 4; k++) write_word(p[k*32 +: 32]);
  endtask

  task automatic read_word(output logic [31:0] w);
    w = out_rdata; out_re = 1'b1;
    @(negedge clk);
    out_re = 1'b0;
  endtask

  task automatic wait_out();
    for (int n = 0; n < 200 && !out_rdy; n++) @(negedge clk);
  endtask

  task automatic read_block(input string req, input logic [127:0] c);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) begin
      read_word(w);
      chk(req, 128'(w), 128'(c[k*32 +: 32]));
      if (k == 2) chk("R7 out_rdy held before last read", 128'(out_rdy), 128'd1);
    end
    chk("R7 out_rdy falls after last read", 128'(out_rdy), 128'd0);
  endtask

  task automatic t_reset();
    chk("R1 in_rdy", 128'(in_rdy), 128'd1);
    chk("R1 out_rdy", 128'(out_rdy), 128'd0);
    chk("R1 irq_idx", 128'(irq_idx), 128'd2);
    chk("R1 core_start", 128'(core_start), 128'd0);
    chk("R1 dma_trig_in", 128'(dma_trig_in), 128'd1);
    chk("R1 dma_trig_out", 128'(dma_trig_out), 128'd0);
  endtask

  task automatic t_first(input logic [127:0] iv, input logic [127:0] p);
    logic [31:0] junk;
    load_iv(iv);
    write_block(p);
    chk("R6 in_rdy low after fourth write", 128'(in_rdy), 128'd0);
    chk("R8 irq_idx none pending", 128'(irq_idx), 128'd0);
    write_word(32'hDEAD_BEEF);
    wait_out();
    chk("R2 R3 core_din first block", last_din, p ^ iv);
    chk("R12 one start per block", 128'(starts), 128'd1);
    chk("R8 irq_idx output ready", 128'(irq_idx), 128'd1);
    chk("R9 dma_trig_out high", 128'(dma_trig_out), 128'd1);
    prev_c = xform(p ^ iv);
    read_block("R5 first ciphertext word", prev_c);
    chk("R8 irq_idx back to input", 128'(irq_idx), 128'd2);
    read_word(junk);
    chk("R7 read when empty ignored", 128'(out_rdy), 128'd0);
  endtask

  task automatic t_chain(input logic [127:0] p);
    write_block(p);
    wait_out();
    chk("R6 ignored write kept alignment, R4 chained input", last_din, p ^ prev_c);
    prev_c = xform(p ^ prev_c);
    read_block("R4 chained ciphertext", prev_c);
  endtask

  task automatic t_backpressure(input logic [127:0] pa, input logic [127:0] pb);
    int s0;
    logic [127:0] ca;
    write_block(pa);
    wait_out();
    ca = xform(pa ^ prev_c);
    chk("R8 both pending in_rdy", 128'(in_rdy), 128'd1);
    chk("R8 output ready reported first", 128'(irq_idx), 128'd1);
    write_block(pb);
    s0 = starts;
    repeat (10) @(negedge clk);
    chk("R10 no start while output unread", 128'(starts), 128'(s0));
    chk("R10 output still pending", 128'(out_rdy), 128'd1);
    read_block("R10 held ciphertext", ca);
    wait_out();
    chk("R4 chained after stall", last_din, pb ^ ca);
    prev_c = xform(pb ^ ca);
    read_block("R4 stalled block ciphertext", prev_c);
  endtask

  task automatic t_iv_reload(input logic [127:0] iv, input logic [127:0] p);
    load_iv(iv);
    write_block(p);
    wait_out();
    chk("R11 new IV restarts chain", last_din, p ^ iv);
    prev_c = xform(p ^ iv);
    read_block("R11 ciphertext after reload", prev_c);
  endtask

  task automatic t_dma(input logic [127:0] p);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 50 && !dma_trig_in; n++) @(negedge clk);
      chk("R9 input request before word", 128'(dma_trig_in), 128'd1);
      write_word(p[k*32 +: 32]);
      chk("R9 input request drops after write", 128'(dma_trig_in), 128'd0);
      @(negedge clk);
    end
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 200 && !dma_trig_out; n++) @(negedge clk);
      chk("R9 output request before word", 128'(dma_trig_out), 128'd1);
      if (k == 0) begin
        chk("R4 dma block chained", last_din, p ^ prev_c);
        prev_c = xform(p ^ prev_c);
      end
      read_word(w);
      chk("R5 dma ciphertext word", 128'(w), 128'(prev_c[k*32 +: 32]));
      chk("R9 output request drops after read", 128'(dma_trig_out), 128'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first(128'h00112233_44556677_8899AABB_CCDDEEFF, 128'h01234567_89ABCDEF_FEDCBA98_76543210);
    t_chain(128'hCAFEF00D_12345678_9ABCDEF0_0BADC0DE);
    t_backpressure(128'h11111111_22222222_33333333_44444444,
                   128'hA0A1A2A3_B0B1B2B3_C0C1C2C3_D0D1D2D3);
    t_iv_reload(128'hFFEEDDCC_BBAA9988_77665544_33221100, 128'h5A5A5A5A_A5A5A5A5_0F0F0F0F_F0F0F0F0);
    t_dma(128'h13579BDF_2468ACE0_FDB97531_0ECA8642);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule